// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of every hardware thread of a multithreaded front end and moves it forward each cycle. Four downstream stages (decode, rename, execute, commit) each send per-thread block and unblock strobes. These strobes set and clear sticky stall flags. Commit and decode can each redirect a thread to a new program counter. Commit can also report that it is still draining. The instruction-cache side appears only as per-thread event strobes: request missed, request refused, refused request accepted on retry, and data returned.

Each cycle the controller applies the redirect and stall requests to every active thread in a fixed order of precedence. It reports which threads may be picked for fetch, and grants one of them through a round-robin priority order. It also keeps a stage-level activity flag, with one-cycle pulses when that flag turns on or off. Threads that are marked inactive keep their state, their program counter and their stall flags unchanged.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Each thread has four sticky stall flags, selected by bit index: 0 decode, 1 rename, 2 execute, 3 commit. A block strobe sets a flag and an unblock strobe clears it. The flag's new value is used in the same cycle. A stalled thread that is not waiting on the cache goes to BLOCKED (code 3). A BLOCKED thread whose flags are all clear returns to RUNNING (code 1).
- R2: While the context-switch input is high, every active thread is treated as stalled and goes to BLOCKED (3). Once the input drops, each thread returns to RUNNING (1) if no flag is set.
- R3: A commit redirect has the highest priority. It loads the thread's PC and next-PC from the commit buses and enters SQUASHING (code 2). While commit reports that it is still draining, the thread stays in SQUASHING (2). A thread in SQUASHING with no redirect and no stall returns to RUNNING (1).
- R4: A decode redirect loads the PC and next-PC from the decode buses and enters SQUASHING (2). It does this only if the thread is not already in SQUASHING. In that case it is ignored: the PC is unchanged and the thread returns to RUNNING (1). A decode redirect takes precedence over a stall.
- R5: Cache events move the thread as follows:
  - From RUNNING (1), a miss goes to WAIT_RESP (code 4) and a refusal goes to WAIT_RETRY (code 5).
  - From WAIT_RETRY, an accepted retry goes to WAIT_RESP.
  - From WAIT_RESP, returned data goes to ACC_DONE (code 6), or to BLOCKED (3) if a stall applies.
  - A stall never moves a thread out of WAIT_RESP or WAIT_RETRY. Either redirect does, by entering SQUASHING.
- R6: A thread is eligible only if it is active and in RUNNING (1), ACC_DONE (6) or IDLE (0). When the fetch request is high and a thread is eligible, the grant goes to the first eligible thread in the priority order, and that thread moves to the back of the order. The order after reset is 0,1,...,N-1. With no eligible thread, or no request, the grant-valid flag is low.
- R7: A thread in ACC_DONE (6) that is granted returns to RUNNING (1) on the next cycle. If it is not granted, it stays in ACC_DONE.
- R8: The stage is active when any active thread's next state is RUNNING, SQUASHING or ACC_DONE. The activate output pulses for one cycle when the stage turns active, in the same cycle as the active flag rises. The deactivate output pulses for one cycle when the stage turns inactive.
- R9: After reset every thread is in RUNNING (1) with PC equal to the reset PC (default 0) and next-PC 4 beyond it, and the stage is inactive. An inactive thread ignores every strobe: its state, PC and stall flags are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_active_i | input | NTHR | Per-thread active mask |
| ctx_switch_i | input | 1 | Global stall for all threads |
| stage_block_i | input | 4 x NTHR | Block strobes, indexed [stage][thread] |
| stage_unblock_i | input | 4 x NTHR | Unblock strobes, indexed [stage][thread] |
| cmt_squash_i | input | NTHR | Commit redirect |
| cmt_squashing_i | input | NTHR | Commit still draining |
| cmt_pc_i | input | NTHR x PC_W | Commit redirect PC |
| cmt_npc_i | input | NTHR x PC_W | Commit redirect next-PC |
| dec_squash_i | input | NTHR | Decode redirect |
| dec_pc_i | input | NTHR x PC_W | Decode redirect PC |
| dec_npc_i | input | NTHR x PC_W | Decode redirect next-PC |
| cache_miss_i | input | NTHR | Request sent, awaiting data |
| cache_nack_i | input | NTHR | Request refused |
| cache_retry_ok_i | input | NTHR | Refused request accepted |
| cache_resp_i | input | NTHR | Data returned |
| fetch_req_i | input | 1 | Ask for a thread grant this cycle |
| thread_state_o | output | NTHR x 4 | State code per thread |
| thread_pc_o | output | NTHR x PC_W | PC per thread |
| thread_npc_o | output | NTHR x PC_W | Next-PC per thread |
| eligible_o | output | NTHR | Eligible-for-grant mask |
| grant_valid_o | output | 1 | A thread is granted |
| grant_id_o | output | log2(NTHR) | Granted thread |
| stage_active_o | output | 1 | Stage activity flag |
| stage_activate_o | output | 1 | One-cycle pulse on turning active |
| stage_deactivate_o | output | 1 | One-cycle pulse on turning inactive |

## Verification
The assertions assume that, for any thread and stage, a block strobe and an unblock strobe never arrive together, and that an unblock only follows a block. They also assume that cache events arrive only in the states that expect them. The checker enforces the same-cycle exclusion as an input property. The stimulus table and the directed tests pair every unblock with an earlier block of the same stage and thread. They raise a miss or refusal only from RUNNING, an accepted retry only from WAIT_RETRY, and returned data only from WAIT_RESP. Redirects are allowed in any state, because that is where the precedence order matters.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_RUN        = 4'd1,
    ST_SQUASH     = 4'd2,
    ST_BLOCK      = 4'd3,
    ST_WAIT_RESP  = 4'd4,
    ST_WAIT_RETRY = 4'd5,
    ST_ACC_DONE   = 4'd6,
    ST_TRAP       = 4'd7,
    ST_QUIESCE    = 4'd8
  } fstate_e;

  localparam int unsigned NUM_STAGES = 4;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned NSTG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTHR-1:0]            thr_en_i,
  input  logic [NSTG-1:0][NTHR-1:0]  set_i,
  input  logic [NSTG-1:0][NTHR-1:0]  clr_i,
  output logic [NTHR-1:0]            stalled_o
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [NSTG-1:0] flg_q;
    logic [NSTG-1:0] flg_d;

    // Set dominates; the updated value feeds the same-cycle stall decision.
    always_comb begin
      for (int s = 0; s < NSTG; s++) begin
        if (set_i[s][t])      flg_d[s] = 1'b1;
        else if (clr_i[s][t]) flg_d[s] = 1'b0;
        else                  flg_d[s] = flg_q[s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flg_q <= '0;
      else if (thr_en_i[t])   flg_q <= flg_d;
    end

    assign stalled_o[t] = |flg_d;
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            stall_i,
  input  logic            cmt_sq_i,
  input  logic            cmt_sqing_i,
  input  logic [PC_W-1:0] cmt_pc_i,
  input  logic [PC_W-1:0] cmt_npc_i,
  input  logic            dec_sq_i,
  input  logic [PC_W-1:0] dec_pc_i,
  input  logic [PC_W-1:0] dec_npc_i,
  input  logic            miss_i,
  input  logic            nack_i,
  input  logic            retry_ok_i,
  input  logic            resp_i,
  input  logic            pick_i,
  output fstate_e         state_o,
  output fstate_e         state_nxt_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] RESET_NPC = RESET_PC + PC_W'(INST_BYTES);

  fstate_e         st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d, npc_q, npc_d;
  logic            waiting;

  assign waiting = (st_q == ST_WAIT_RESP) || (st_q == ST_WAIT_RETRY);

  // Precedence: commit redirect, commit draining, decode redirect, stall, recovery.
  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    npc_d = npc_q;
    if (cmt_sq_i) begin
      st_d  = ST_SQUASH;
      pc_d  = cmt_pc_i;
      npc_d = cmt_npc_i;
    end else if (cmt_sqing_i) begin
      st_d = ST_SQUASH;
    end else if (dec_sq_i && st_q != ST_SQUASH) begin
      st_d  = ST_SQUASH;
      pc_d  = dec_pc_i;
      npc_d = dec_npc_i;
    end else if (stall_i && !waiting) begin
      st_d = ST_BLOCK;
    end else if (st_q == ST_BLOCK || st_q == ST_SQUASH) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (miss_i)      st_d = ST_WAIT_RESP;
          else if (nack_i) st_d = ST_WAIT_RETRY;
        end
        ST_WAIT_RETRY: if (retry_ok_i) st_d = ST_WAIT_RESP;
        ST_WAIT_RESP:  if (resp_i)     st_d = stall_i ? ST_BLOCK : ST_ACC_DONE;
        ST_ACC_DONE:   if (pick_i)     st_d = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      pc_q  <= RESET_PC;
      npc_q <= RESET_NPC;
    end else if (en_i) begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      npc_q <= npc_d;
    end
  end

  assign state_o     = st_q;
  assign state_nxt_o = en_i ? st_d : st_q;
  assign pc_o        = pc_q;
  assign npc_o       = npc_q;
endmodule

// File: rtl/fsc_rr_pick.sv
module fsc_rr_pick #(
  parameter int unsigned NTHR = 4,
  localparam int unsigned TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic [NTHR-1:0] elig_i,
  output logic            gnt_valid_o,
  output logic [TW-1:0]   gnt_id_o,
  output logic [NTHR-1:0] gnt_oh_o
);
  logic [TW-1:0] order_q [NTHR];
  logic [TW-1:0] order_d [NTHR];
  logic          hit;
  logic [TW-1:0] pos;
  logic          upd_en;

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = 0; p < NTHR; p++) begin
      if (!hit && elig_i[order_q[p]]) begin
        hit = 1'b1;
        pos = TW'(p);
      end
    end
  end

  assign gnt_id_o    = order_q[pos];
  assign gnt_valid_o = req_i && hit;
  assign upd_en      = gnt_valid_o;

  // Remove the granted entry and append it at the tail.
  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      if (i < int'(pos))     order_d[i] = order_q[i];
      else if (i < NTHR - 1) order_d[i] = order_q[i+1];
      else                   order_d[i] = gnt_id_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= TW'(i);
    end else if (upd_en) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= order_d[i];
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_oh
    assign gnt_oh_o[t] = gnt_valid_o && (gnt_id_o == TW'(t));
  end
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int unsigned     NTHR       = 4,
  parameter int unsigned     PC_W       = 32,
  parameter int unsigned     INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  localparam int unsigned    NSTG       = NUM_STAGES,
  localparam int unsigned    TW         = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTHR-1:0]            thread_active_i,
  input  logic                       ctx_switch_i,
  input  logic [NSTG-1:0][NTHR-1:0]  stage_block_i,
  input  logic [NSTG-1:0][NTHR-1:0]  stage_unblock_i,
  input  logic [NTHR-1:0]            cmt_squash_i,
  input  logic [NTHR-1:0]            cmt_squashing_i,
  input  logic [NTHR-1:0][PC_W-1:0]  cmt_pc_i,
  input  logic [NTHR-1:0][PC_W-1:0]  cmt_npc_i,
  input  logic [NTHR-1:0]            dec_squash_i,
  input  logic [NTHR-1:0][PC_W-1:0]  dec_pc_i,
  input  logic [NTHR-1:0][PC_W-1:0]  dec_npc_i,
  input  logic [NTHR-1:0]            cache_miss_i,
  input  logic [NTHR-1:0]            cache_nack_i,
  input  logic [NTHR-1:0]            cache_retry_ok_i,
  input  logic [NTHR-1:0]            cache_resp_i,
  input  logic                       fetch_req_i,
  output logic [NTHR-1:0][3:0]       thread_state_o,
  output logic [NTHR-1:0][PC_W-1:0]  thread_pc_o,
  output logic [NTHR-1:0][PC_W-1:0]  thread_npc_o,
  output logic [NTHR-1:0]            eligible_o,
  output logic                       grant_valid_o,
  output logic [TW-1:0]              grant_id_o,
  output logic                       stage_active_o,
  output logic                       stage_activate_o,
  output logic                       stage_deactivate_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NTHR-1:0] stalled;
  logic [NTHR-1:0] pick_oh;
  logic [NTHR-1:0] busy_nxt;
  fstate_e         st_cur [NTHR];
  fstate_e         st_nxt [NTHR];

  fsc_stall_flags #(.NTHR(NTHR), .NSTG(NSTG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .thr_en_i  (thread_active_i),
    .set_i     (stage_block_i),
    .clr_i     (stage_unblock_i),
    .stalled_o (stalled)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    fsc_thread_fsm #(.PC_W(PC_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .en_i        (thread_active_i[t]),
      .stall_i     (stalled[t] | ctx_switch_i),
      .cmt_sq_i    (cmt_squash_i[t]),
      .cmt_sqing_i (cmt_squashing_i[t]),
      .cmt_pc_i    (cmt_pc_i[t]),
      .cmt_npc_i   (cmt_npc_i[t]),
      .dec_sq_i    (dec_squash_i[t]),
      .dec_pc_i    (dec_pc_i[t]),
      .dec_npc_i   (dec_npc_i[t]),
      .miss_i      (cache_miss_i[t]),
      .nack_i      (cache_nack_i[t]),
      .retry_ok_i  (cache_retry_ok_i[t]),
      .resp_i      (cache_resp_i[t]),
      .pick_i      (pick_oh[t]),
      .state_o     (st_cur[t]),
      .state_nxt_o (st_nxt[t]),
      .pc_o        (thread_pc_o[t]),
      .npc_o       (thread_npc_o[t])
    );

    assign thread_state_o[t] = st_cur[t];
    assign eligible_o[t]     = thread_active_i[t] &&
                               (st_cur[t] == ST_RUN || st_cur[t] == ST_ACC_DONE ||
                                st_cur[t] == ST_IDLE);
    assign busy_nxt[t]       = thread_active_i[t] &&
                               (st_nxt[t] == ST_RUN || st_nxt[t] == ST_SQUASH ||
                                st_nxt[t] == ST_ACC_DONE);
  end

  fsc_rr_pick #(.NTHR(NTHR)) u_pick (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_i       (fetch_req_i),
    .elig_i      (eligible_o),
    .gnt_valid_o (grant_valid_o),
    .gnt_id_o    (grant_id_o),
    .gnt_oh_o    (pick_oh)
  );

  // Stage activity flag and transition pulses.
  logic act_d, on_d, off_d;
  logic act_q, on_q, off_q;

  always_comb begin
    act_d = |busy_nxt;
    on_d  = act_d && !act_q;
    off_d = !act_d && act_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_q <= 1'b0;
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      act_q <= act_d;
      on_q  <= on_d;
      off_q <= off_d;
    end
  end

  assign stage_active_o     = act_q;
  assign stage_activate_o   = on_q;
  assign stage_deactivate_o = off_q;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int unsigned NTHR = 4,
  parameter int unsigned PC_W = 32,
  parameter int unsigned NSTG = 4,
  localparam int unsigned TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NTHR-1:0]            thread_active_i,
  input logic [NSTG-1:0][NTHR-1:0]  stage_block_i,
  input logic [NSTG-1:0][NTHR-1:0]  stage_unblock_i,
  input logic [NTHR-1:0]            cmt_squash_i,
  input logic [NTHR-1:0]            cmt_squashing_i,
  input logic [NTHR-1:0]            dec_squash_i,
  input logic [NTHR-1:0][PC_W-1:0]  cmt_pc_i,
  input logic [NTHR-1:0]            cache_resp_i,
  input logic                       fetch_req_i,
  input logic [NTHR-1:0][3:0]       thread_state_o,
  input logic [NTHR-1:0][PC_W-1:0]  thread_pc_o,
  input logic [NTHR-1:0]            eligible_o,
  input logic                       grant_valid_o,
  input logic [TW-1:0]              grant_id_o,
  input logic                       stage_active_o,
  input logic                       stage_activate_o,
  input logic                       stage_deactivate_o
);
  logic [NTHR-1:0] strobe_clash;

  always_comb begin
    strobe_clash = '0;
    for (int s = 0; s < NSTG; s++) strobe_clash |= stage_block_i[s] & stage_unblock_i[s];
  end

  // Input rule for R1: a block and an unblock never arrive together.
  p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_clash == '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    p_commit_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active_i[t] && cmt_squash_i[t]) |=>
        (thread_state_o[t] == 4'd2 && thread_pc_o[t] == $past(cmt_pc_i[t])));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thread_active_i[t] && thread_state_o[t] == 4'd4 && !cmt_squash_i[t] &&
       !cmt_squashing_i[t] && !dec_squash_i[t] && !cache_resp_i[t]) |=>
        (thread_state_o[t] == 4'd4));

    p_inactive_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !thread_active_i[t] |=> ($stable(thread_state_o[t]) && $stable(thread_pc_o[t])));
  end

  p_grant_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> (fetch_req_i && eligible_o[grant_id_o]));

  p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(stage_activate_o && stage_deactivate_o));

  p_activate_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stage_activate_o |-> (stage_active_o && !$past(stage_active_o)));

  p_deactivate_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stage_deactivate_o |-> (!stage_active_o && $past(stage_active_o)));
endmodule

bind fetch_status_ctrl fsc_checker #(.NTHR(NTHR), .PC_W(PC_W), .NSTG(NSTG)) u_chk (
  .clk                (clk),
  .rst_n              (rst_sync_n),
  .thread_active_i    (thread_active_i),
  .stage_block_i      (stage_block_i),
  .stage_unblock_i    (stage_unblock_i),
  .cmt_squash_i       (cmt_squash_i),
  .cmt_squashing_i    (cmt_squashing_i),
  .dec_squash_i       (dec_squash_i),
  .cmt_pc_i           (cmt_pc_i),
  .cache_resp_i       (cache_resp_i),
  .fetch_req_i        (fetch_req_i),
  .thread_state_o     (thread_state_o),
  .thread_pc_o        (thread_pc_o),
  .eligible_o         (eligible_o),
  .grant_valid_o      (grant_valid_o),
  .grant_id_o         (grant_id_o),
  .stage_active_o     (stage_active_o),
  .stage_activate_o   (stage_activate_o),
  .stage_deactivate_o (stage_deactivate_o)
);

// File: tb/sim_fetch_status_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_status_ctrl;
  localparam int NT = 4;
  localparam int PW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NT-1:0] thread_active;
  logic ctx_switch;
  logic [3:0][NT-1:0] stage_block, stage_unblock;
  logic [NT-1:0] cmt_squash, cmt_squashing, dec_squash;
  logic [NT-1:0][PW-1:0] cmt_pc, cmt_npc, dec_pc, dec_npc;
  logic [NT-1:0] cache_miss, cache_nack, cache_retry_ok, cache_resp;
  logic fetch_req;
  logic [NT-1:0][3:0] thread_state;
  logic [NT-1:0][PW-1:0] thread_pc, thread_npc;
  logic [NT-1:0] eligible;
  logic grant_valid;
  logic [1:0] grant_id;
  logic stage_active, stage_activate, stage_deactivate;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fetch_status_ctrl #(.NTHR(NT), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .thread_active_i(thread_active), .ctx_switch_i(ctx_switch),
    .stage_block_i(stage_block), .stage_unblock_i(stage_unblock),
    .cmt_squash_i(cmt_squash), .cmt_squashing_i(cmt_squashing),
    .cmt_pc_i(cmt_pc), .cmt_npc_i(cmt_npc),
    .dec_squash_i(dec_squash), .dec_pc_i(dec_pc), .dec_npc_i(dec_npc),
    .cache_miss_i(cache_miss), .cache_nack_i(cache_nack),
    .cache_retry_ok_i(cache_retry_ok), .cache_resp_i(cache_resp),
    .fetch_req_i(fetch_req), .thread_state_o(thread_state),
    .thread_pc_o(thread_pc), .thread_npc_o(thread_npc), .eligible_o(eligible),
    .grant_valid_o(grant_valid), .grant_id_o(grant_id),
    .stage_active_o(stage_active), .stage_activate_o(stage_activate),
    .stage_deactivate_o(stage_deactivate)
  );

  // Row: {block[3:0], unblock[3:0], cmt_sq, cmt_sqing, dec_sq, miss, nack, retry_ok, resp, expected state}
  // Stage bits: 0 decode, 1 rename, 2 execute, 3 commit. Applied to thread 0.
  localparam int NROWS = 23;
  localparam logic [18:0] TBL [NROWS] = '{
    {4'b0000, 4'b0000, 7'b0000000, 4'd1},  // R1 idle cycle stays running
    {4'b0001, 4'b0000, 7'b0000000, 4'd3},  // R1 decode block
    {4'b0000, 4'b0000, 7'b0000000, 4'd3},  // R1 sticky
    {4'b0000, 4'b0001, 7'b0000000, 4'd1},  // R1 unblock recovers
    {4'b0000, 4'b0000, 7'b0001000, 4'd4},  // R5 miss
    {4'b0010, 4'b0000, 7'b0000000, 4'd4},  // R5 stall ignored while waiting
    {4'b0000, 4'b0000, 7'b0000001, 4'd3},  // R5 data returns while stalled
    {4'b0000, 4'b0010, 7'b0000000, 4'd1},  // R1 rename unblock
    {4'b0000, 4'b0000, 7'b0000100, 4'd5},  // R5 refusal
    {4'b0000, 4'b0000, 7'b0000010, 4'd4},  // R5 retry accepted
    {4'b0000, 4'b0000, 7'b0000001, 4'd6},  // R5 data returns
    {4'b0000, 4'b0000, 7'b0000000, 4'd6},  // R7 no grant, holds
    {4'b0000, 4'b0000, 7'b0010000, 4'd2},  // R4 decode redirect
    {4'b0000, 4'b0000, 7'b0100000, 4'd2},  // R3 commit draining
    {4'b0000, 4'b0000, 7'b0010000, 4'd1},  // R4 ignored while squashing
    {4'b0100, 4'b0000, 7'b1000000, 4'd2},  // R3 commit redirect beats stall
    {4'b0000, 4'b0000, 7'b0000000, 4'd3},  // R1 execute flag held
    {4'b0000, 4'b0100, 7'b0010000, 4'd2},  // R4 decode redirect from blocked
    {4'b1000, 4'b0000, 7'b0100000, 4'd2},  // R3 draining beats stall
    {4'b0000, 4'b1000, 7'b0000000, 4'd1},  // R3 squashing returns to running
    {4'b0000, 4'b0000, 7'b0001000, 4'd4},  // R5 miss
    {4'b0000, 4'b0000, 7'b1000000, 4'd2},  // R5 redirect cancels wait
    {4'b0000, 4'b0000, 7'b0000000, 4'd1}   // R3 recovery
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ctx_switch = 0; stage_block = '0; stage_unblock = '0;
    cmt_squash = '0; cmt_squashing = '0; dec_squash = '0;
    cache_miss = '0; cache_nack = '0; cache_retry_ok = '0; cache_resp = '0;
    fetch_req = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    clear_inputs();
    thread_active = '0;
    rst_n = 0;
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      cmt_pc[t] = 32'h1000; cmt_npc[t] = 32'h1004;
      dec_pc[t] = 32'h2000; dec_npc[t] = 32'h2004;
    end
    do_reset();

    // R9 reset state
    for (int t = 0; t < NT; t++) begin
      check("R9 reset state", thread_state[t], 4'd1);
      check("R9 reset pc", thread_pc[t], 32'h0);
      check("R9 reset npc", thread_npc[t], 32'h4);
    end
    check("R9 reset stage inactive", stage_active, 1'b0);
    fetch_req = 1; #1;
    check("R6 inactive threads not eligible", eligible, 4'b0000);
    check("R6 no grant when none eligible", grant_valid, 1'b0);
    fetch_req = 0;

    // Table walk on thread 0
    thread_active = 4'b0001;
    for (int i = 0; i < NROWS; i++) begin
      for (int s = 0; s < 4; s++) begin
        stage_block[s][0]   = TBL[i][15+s];
        stage_unblock[s][0] = TBL[i][11+s];
      end
      cmt_squash[0]     = TBL[i][10];
      cmt_squashing[0]  = TBL[i][9];
      dec_squash[0]     = TBL[i][8];
      cache_miss[0]     = TBL[i][7];
      cache_nack[0]     = TBL[i][6];
      cache_retry_ok[0] = TBL[i][5];
      cache_resp[0]     = TBL[i][4];
      tick();
      check($sformatf("R1 R3 R4 R5 table row %0d", i), thread_state[0], TBL[i][3:0]);
      clear_inputs();
    end

    // R3 and R4: program counter loading
    do_reset();
    thread_active = 4'b0010;
    dec_squash[1] = 1; dec_pc[1] = 32'h200; dec_npc[1] = 32'h204;
    tick(); clear_inputs();
    check("R4 decode redirect state", thread_state[1], 4'd2);
    check("R4 decode redirect pc", thread_pc[1], 32'h200);
    check("R4 decode redirect npc", thread_npc[1], 32'h204);
    dec_squash[1] = 1; dec_pc[1] = 32'h300; dec_npc[1] = 32'h304;
    tick(); clear_inputs();
    check("R4 ignored while squashing state", thread_state[1], 4'd1);
    check("R4 ignored while squashing pc", thread_pc[1], 32'h200);
    cmt_squash[1] = 1; cmt_pc[1] = 32'h400; cmt_npc[1] = 32'h404;
    dec_squash[1] = 1; dec_pc[1] = 32'h500;
    tick(); clear_inputs();
    check("R3 commit beats decode state", thread_state[1], 4'd2);
    check("R3 commit beats decode pc", thread_pc[1], 32'h400);
    check("R3 commit beats decode npc", thread_npc[1], 32'h404);

    // R8 activity pulses
    do_reset();
    thread_active = 4'b0001;
    tick();
    check("R8 stage turns active", stage_active, 1'b1);
    check("R8 activate pulse", stage_activate, 1'b1);
    check("R8 no deactivate", stage_deactivate, 1'b0);
    tick();
    check("R8 activate one cycle", stage_activate, 1'b0);
    stage_block[0][0] = 1;
    tick(); clear_inputs();
    check("R8 stage turns inactive", stage_active, 1'b0);
    check("R8 deactivate pulse", stage_deactivate, 1'b1);
    tick();
    check("R8 deactivate one cycle", stage_deactivate, 1'b0);

    // R2 context switch
    do_reset();
    thread_active = 4'b1111;
    ctx_switch = 1;
    tick();
    for (int t = 0; t < NT; t++) check("R2 context switch blocks", thread_state[t], 4'd3);
    ctx_switch = 0;
    tick();
    for (int t = 0; t < NT; t++) check("R2 release recovers", thread_state[t], 4'd1);

    // R9 inactive thread ignores strobes
    do_reset();
    thread_active = 4'b0001;
    stage_block[0][2] = 1; cmt_squash[2] = 1; cmt_pc[2] = 32'h900;
    tick(); clear_inputs();
    check("R9 inactive state held", thread_state[2], 4'd1);
    check("R9 inactive pc held", thread_pc[2], 32'h0);
    thread_active = 4'b1111;
    tick();
    check("R9 inactive flag not set", thread_state[2], 4'd1);

    // R6 round-robin order
    do_reset();
    thread_active = 4'b1111;
    stage_block[0][1] = 1;
    tick(); clear_inputs();
    check("R6 blocked thread state", thread_state[1], 4'd3);
    check("R6 eligible mask", eligible, 4'b1101);
    begin
      int exp_seq [5] = '{0, 2, 3, 0, 2};
      fetch_req = 1;
      for (int k = 0; k < 5; k++) begin
        #1;
        check("R6 grant valid", grant_valid, 1'b1);
        check($sformatf("R6 grant order step %0d", k), grant_id, exp_seq[k]);
        tick();
      end
    end
    ctx_switch = 1;
    tick();
    #1;
    check("R6 no-grant when all blocked", grant_valid, 1'b0);
    clear_inputs();

    // R7 access-complete thread returns to running when granted
    do_reset();
    thread_active = 4'b0001;
    cache_miss[0] = 1; tick(); clear_inputs();
    cache_resp[0] = 1; tick(); clear_inputs();
    check("R7 access complete", thread_state[0], 4'd6);
    fetch_req = 1; #1;
    check("R7 grant to access-complete thread", grant_valid, 1'b1);
    check("R7 grant id", grant_id, 2'd0);
    tick(); clear_inputs();
    check("R7 granted returns to running", thread_state[0], 4'd1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule